// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command bus of a four-bank synchronous DRAM from the controller side. On every rising clock edge it decodes the active-low chip-select, row-strobe, column-strobe and write-enable lines. It keeps an open or idle state and an open-row register for each bank. It also times the recovery windows that follow a bank close and a refresh, and it records the operating word sent by a mode-load command.

Each command is checked against the bank state before it is allowed to change anything. A rejected command raises exactly one violation flag for one cycle and leaves every piece of state alone. A controller or a monitor can use the per-bank ready outputs to decide when a bank may take its next command. Recovery times and the burst length used by self-closing accesses come in as cycle counts on configuration inputs.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `cs_n` is high the command is inhibited. No bank state, open row or mode word changes, and no violation flag rises. Timers already running keep counting.
- R2: With `cs_n` low, the lines {`ras_n`,`cas_n`,`we_n`} encode the command: 011 open a row, 101 read, 100 write, 010 close, 001 refresh, 000 mode load. Codes 111 and 110 have no effect. An accepted open marks bank `ba` active and stores `addr` as its row in `open_row[b*11 +: 11]`. The row stays open until the bank is closed.
- R3: A read or write to an idle bank, or an open to a bank that is already open, sets `viol_state` for one cycle and changes no state.
- R4: A close with `addr[10]` high targets every bank and ignores `ba`. With `addr[10]` low it targets only bank `ba`. Each targeted bank that is open becomes idle.
- R5: A bank that is closed on edge P refuses open, read and write commands until edge P+`cfg_trp`. Such a command sets `viol_early` for one cycle and changes nothing. `bank_ready[b]` is low from edge P until edge P+`cfg_trp`-1.
- R6: A mode load is accepted only when every bank is idle. It then captures `addr` into `mode_word`. With a bank open it sets `viol_open` and leaves `mode_word` unchanged.
- R7: A refresh is accepted only when every bank is idle and recovered. With a bank open it sets `viol_open`. An accepted refresh on edge F drops every `bank_ready` bit until edge F+`cfg_trc`-1, and it refuses every command before edge F+`cfg_trc` with `viol_early`.
- R8: A read or write with `addr[10]` high closes its bank by itself on edge W+`cfg_burst`, where W is the command edge. Recovery per R5 then starts at that edge.
- R9: After reset every bank is idle and ready, all rows and `mode_word` are zero, and all violation flags are low.
- R10: At most one violation flag is high in any cycle. A recovery violation takes priority over a state or open-bank violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Row, column or operating word; bit 10 selects self-close or all-bank close |
| cfg_trp | input | 4 | Close-to-reuse recovery in cycles (0 treated as 1) |
| cfg_trc | input | 4 | Refresh recovery in cycles (0 treated as 1) |
| cfg_burst | input | 4 | Burst length in cycles for self-closing accesses (0 treated as 1) |
| bank_active | output | 4 | One bit per bank, high while a row is open |
| open_row | output | 44 | Row stored for bank b in bits [b*11 +: 11] |
| bank_ready | output | 4 | High when bank b may take an open, read or write |
| mode_word | output | 11 | Last accepted operating word |
| viol_early | output | 1 | One-cycle pulse: command issued inside a recovery window |
| viol_state | output | 1 | One-cycle pulse: access to an idle bank or open of an open bank |
| viol_open | output | 1 | One-cycle pulse: mode load or refresh with a bank open |

## Verification
A wrong bank state shows at `bank_active` on the next sample. It also shows one command later as a false or missing `viol_state` pulse when that bank is accessed. A recovery counter that is off by one moves the edge at which `bank_ready` rises by a cycle, and it changes whether a command issued exactly at the recovery boundary is flagged. A miscounted self-close burst shows up as the bank dropping out of `bank_active` one cycle too early or too late. The bench samples every one of these boundary cycles.

// File: rtl/sbt_pkg.sv
// Shared types for the SDRAM bank state tracker.
// Assumes active-low command lines and an inhibit whenever chip select is high.
package sbt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_OPEN,
        CMD_READ,
        CMD_WRITE,
        CMD_CLOSE,
        CMD_REFRESH,
        CMD_MODE,
        CMD_STOP
    } sbt_cmd_e;

    // Map the four strobe lines onto a command; chip select high is a no-op.
    function automatic sbt_cmd_e sbt_decode(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        sbt_cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_OPEN;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b010:  c = CMD_CLOSE;
                3'b001:  c = CMD_REFRESH;
                3'b000:  c = CMD_MODE;
                3'b110:  c = CMD_STOP;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sbt_cmd_decode.sv
// Command decoder: turns the strobe lines and bank address into a command
// code, a one-hot bank target and a target mask for bank close.
// Assumes BANKS is a power of two matching the width of ba.
module sbt_cmd_decode
    import sbt_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ADDR_W = 11,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output sbt_cmd_e          cmd,
    output logic [BANKS-1:0]  ba_hot,
    output logic [BANKS-1:0]  close_mask,
    output logic              flag_bit
);
    localparam int FLAG_POS = ADDR_W - 1;

    // Command code from the strobe lines.
    always_comb cmd = sbt_decode(cs_n, ras_n, cas_n, we_n);

    // The flag bit selects self-close on accesses and all-bank close on close.
    always_comb flag_bit = addr[FLAG_POS];

    for (genvar b = 0; b < BANKS; b++) begin : g_hot
        // One-hot bank selection and close targeting per bank.
        always_comb begin
            ba_hot[b]     = (ba == BA_W'(b));
            close_mask[b] = flag_bit | (ba == BA_W'(b));
        end
    end

endmodule

// File: rtl/sbt_bank.sv
// One bank's state: open flag, stored row, self-close burst counter and
// close recovery counter. Assumes the parent only asserts do_close on an
// open bank with no self-close pending, and never two requests at once.
module sbt_bank #(
    parameter int ROW_W   = 11,
    parameter int TMR_W   = 4,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_open,
    input  logic               do_close,
    input  logic               do_autoclose,
    input  logic [ROW_W-1:0]   row_in,
    input  logic [TMR_W-1:0]   cfg_trp,
    input  logic [BURST_W-1:0] cfg_burst,
    output logic               active,
    output logic [ROW_W-1:0]   row,
    output logic               recovering,
    output logic               auto_pending
);
    logic [BURST_W-1:0] burst_cnt;
    logic [TMR_W-1:0]   rec_cnt;
    logic [TMR_W-1:0]   rec_load;
    logic [BURST_W-1:0] burst_load;
    logic               auto_fire;

    // Counter reload values; a zero setting behaves as one cycle.
    always_comb begin
        rec_load   = (cfg_trp == '0)   ? '0 : cfg_trp - 1'b1;
        burst_load = (cfg_burst == '0) ? BURST_W'(1) : cfg_burst;
    end

    // The self-close happens on the cycle the burst counter sits at one.
    always_comb auto_fire = auto_pending && (burst_cnt == BURST_W'(1));

    // Open flag and row register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            row    <= '0;
        end else if (do_open) begin
            active <= 1'b1;
            row    <= row_in;
        end else if (do_close || auto_fire) begin
            active <= 1'b0;
        end
    end

    // Burst countdown for a pending self-close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_pending <= 1'b0;
            burst_cnt    <= '0;
        end else if (do_autoclose) begin
            auto_pending <= 1'b1;
            burst_cnt    <= burst_load;
        end else if (auto_fire) begin
            auto_pending <= 1'b0;
            burst_cnt    <= '0;
        end else if (auto_pending) begin
            burst_cnt <= burst_cnt - 1'b1;
        end
    end

    // Recovery countdown started by any close of this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (do_close || auto_fire) begin
            rec_cnt <= rec_load;
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    // Recovery is in progress while the counter is non-zero.
    always_comb recovering = (rec_cnt != '0);

endmodule

// File: rtl/sbt_refresh_timer.sv
// Refresh recovery timer shared by all banks: busy for cfg_trc-1 cycles
// after the refresh edge. Assumes start is only raised for an accepted refresh.
module sbt_refresh_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMR_W-1:0] cfg_trc,
    output logic             busy
);
    logic [TMR_W-1:0] cnt;

    // Load on refresh, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= (cfg_trc == '0) ? '0 : cfg_trc - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Any non-zero count blocks every command.
    always_comb busy = (cnt != '0);

endmodule

// File: rtl/sdram_bank_tracker.sv
// Top level of the bank state tracker. Decodes each command, judges it
// against bank state and recovery timers, applies accepted commands and
// pulses one violation flag for a rejected one.
// Assumes commands are sampled on the rising edge and that a recovery
// violation outranks a state or open-bank violation.
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int BANKS   = 4,
    parameter int ADDR_W  = 11,
    parameter int ROW_W   = 11,
    parameter int TMR_W   = 4,
    parameter int BURST_W = 4,
    localparam int BA_W   = $clog2(BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [TMR_W-1:0]       cfg_trp,
    input  logic [TMR_W-1:0]       cfg_trc,
    input  logic [BURST_W-1:0]     cfg_burst,
    output logic [BANKS-1:0]       bank_active,
    output logic [BANKS*ROW_W-1:0] open_row,
    output logic [BANKS-1:0]       bank_ready,
    output logic [ADDR_W-1:0]      mode_word,
    output logic                   viol_early,
    output logic                   viol_state,
    output logic                   viol_open
);
    sbt_cmd_e         cmd;
    logic [BANKS-1:0] ba_hot;
    logic [BANKS-1:0] close_mask;
    logic             flag_bit;
    logic [BANKS-1:0] recovering;
    logic [BANKS-1:0] auto_pending;
    logic             refresh_busy;

    logic is_bank_cmd, is_rw, is_global;
    logic early, state_err, open_err;
    logic accept;
    logic [BANKS-1:0] do_open, do_close, do_autoclose;

    sbt_cmd_decode #(
        .BANKS (BANKS),
        .ADDR_W(ADDR_W)
    ) u_dec (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .cmd       (cmd),
        .ba_hot    (ba_hot),
        .close_mask(close_mask),
        .flag_bit  (flag_bit)
    );

    sbt_refresh_timer #(
        .TMR_W(TMR_W)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept && (cmd == CMD_REFRESH)),
        .cfg_trc(cfg_trc),
        .busy   (refresh_busy)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sbt_bank #(
            .ROW_W  (ROW_W),
            .TMR_W  (TMR_W),
            .BURST_W(BURST_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .do_open     (do_open[b]),
            .do_close    (do_close[b]),
            .do_autoclose(do_autoclose[b]),
            .row_in      (addr[ROW_W-1:0]),
            .cfg_trp     (cfg_trp),
            .cfg_burst   (cfg_burst),
            .active      (bank_active[b]),
            .row         (open_row[b*ROW_W +: ROW_W]),
            .recovering  (recovering[b]),
            .auto_pending(auto_pending[b])
        );
    end

    // A bank is ready with no recovery, no pending self-close and no refresh.
    always_comb bank_ready = ~recovering & ~auto_pending & {BANKS{~refresh_busy}};

    // Command class flags.
    always_comb begin
        is_rw       = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        is_bank_cmd = (cmd == CMD_OPEN) || is_rw;
        is_global   = (cmd == CMD_MODE) || (cmd == CMD_REFRESH);
    end

    // Judge the command against timers and bank state.
    always_comb begin
        early     = 1'b0;
        state_err = 1'b0;
        open_err  = 1'b0;
        if (is_bank_cmd) begin
            early     = !bank_ready[ba];
            state_err = (cmd == CMD_OPEN) ? bank_active[ba] : !bank_active[ba];
        end else if (cmd == CMD_CLOSE) begin
            early = refresh_busy || (|(close_mask & auto_pending));
        end else if (is_global) begin
            early    = refresh_busy || (|recovering);
            open_err = |bank_active;
        end
    end

    // Accept only a checked command with no violation.
    always_comb accept = (is_bank_cmd || is_global || (cmd == CMD_CLOSE))
                         && !early && !state_err && !open_err;

    // Per-bank requests for the accepted command.
    always_comb begin
        do_open      = (accept && (cmd == CMD_OPEN)) ? ba_hot : '0;
        do_autoclose = (accept && is_rw && flag_bit) ? ba_hot : '0;
        do_close     = (accept && (cmd == CMD_CLOSE)) ? (close_mask & bank_active) : '0;
    end

    // Operating word capture on an accepted mode load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_word <= '0;
        end else if (accept && (cmd == CMD_MODE)) begin
            mode_word <= addr;
        end
    end

    // One-cycle violation pulses, recovery first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_early <= 1'b0;
            viol_state <= 1'b0;
            viol_open  <= 1'b0;
        end else begin
            viol_early <= early;
            viol_state <= !early && state_err;
            viol_open  <= !early && open_err;
        end
    end

endmodule

// File: rtl/sbt_checker.sv
// Property checker for the bank state tracker, bound to the top level.
// Assumes it sees only the top-level ports.
module sbt_checker #(
    parameter int BANKS   = 4,
    parameter int ADDR_W  = 11,
    parameter int ROW_W   = 11,
    parameter int TMR_W   = 4,
    localparam int BA_W   = $clog2(BANKS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BA_W-1:0]        ba,
    input logic [ADDR_W-1:0]      addr,
    input logic [TMR_W-1:0]       cfg_trc,
    input logic [BANKS-1:0]       bank_active,
    input logic [BANKS*ROW_W-1:0] open_row,
    input logic [BANKS-1:0]       bank_ready,
    input logic [ADDR_W-1:0]      mode_word,
    input logic                   viol_early,
    input logic                   viol_state,
    input logic                   viol_open
);
    logic [2:0] strobes;
    always_comb strobes = {ras_n, cas_n, we_n};

    p_inhibit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!viol_early && !viol_state && !viol_open
                  && $stable(mode_word) && $stable(open_row)));

    p_open_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && strobes == 3'b011 && bank_ready[ba] && !bank_active[ba])
        |=> (bank_active[$past(ba)]
             && open_row[$past(ba)*ROW_W +: ROW_W] == $past(addr[ROW_W-1:0])));

    p_idle_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && !cas_n && bank_ready[ba] && !bank_active[ba])
        |=> viol_state);

    p_mode_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && strobes == 3'b000 && (|bank_active))
        |=> ((viol_open || viol_early) && $stable(mode_word)));

    p_refresh_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && strobes == 3'b001 && !(|bank_active) && (&bank_ready) && cfg_trc > 4'd1)
        |=> (bank_ready == '0 && !viol_early && !viol_open));

    p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({viol_early, viol_state, viol_open}));

endmodule

bind sdram_bank_tracker sbt_checker #(
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .ROW_W (ROW_W),
    .TMR_W (TMR_W)
) u_chk (.*);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000, C_INH = 4'b1011;
    localparam int NVEC = 24;
    // {cmd, ba, addr, expected bank_active, expected {early,state,open}}
    localparam logic [23:0] VEC [NVEC] = '{
        {C_NOP, 2'd0, 11'h000, 4'b0000, 3'b000},
        {C_RD,  2'd0, 11'h000, 4'b0000, 3'b010},   // R3 idle read
        {C_ACT, 2'd0, 11'h123, 4'b0001, 3'b000},   // R2
        {C_ACT, 2'd2, 11'h7FF, 4'b0101, 3'b000},   // R2
        {C_ACT, 2'd0, 11'h001, 4'b0101, 3'b010},   // R3 reopen
        {C_MRS, 2'd0, 11'h0AB, 4'b0101, 3'b001},   // R6
        {C_REF, 2'd0, 11'h000, 4'b0101, 3'b001},   // R7
        {C_WR,  2'd2, 11'h010, 4'b0101, 3'b000},
        {C_PRE, 2'd0, 11'h000, 4'b0100, 3'b000},   // R4 single
        {C_ACT, 2'd0, 11'h055, 4'b0100, 3'b100},   // R5 early
        {C_ACT, 2'd0, 11'h055, 4'b0101, 3'b000},   // R5 boundary
        {C_RD,  2'd0, 11'h404, 4'b0101, 3'b000},   // R8 self-close
        {C_NOP, 2'd0, 11'h000, 4'b0101, 3'b000},
        {C_NOP, 2'd0, 11'h000, 4'b0100, 3'b000},   // R8 closed
        {C_ACT, 2'd0, 11'h066, 4'b0100, 3'b100},   // R8 recovery
        {C_PRE, 2'd1, 11'h400, 4'b0000, 3'b000},   // R4 all
        {C_REF, 2'd0, 11'h000, 4'b0000, 3'b100},   // R7 early
        {C_REF, 2'd0, 11'h000, 4'b0000, 3'b000},   // R7
        {C_ACT, 2'd1, 11'h011, 4'b0000, 3'b100},   // R7 block
        {C_INH, 2'd1, 11'h011, 4'b0000, 3'b000},   // R1
        {C_MRS, 2'd0, 11'h2A5, 4'b0000, 3'b000},   // R6
        {C_ACT, 2'd3, 11'h3C0, 4'b1000, 3'b000},   // R2
        {C_WR,  2'd1, 11'h000, 4'b1000, 3'b010},   // R3
        {C_NOP, 2'd0, 11'h000, 4'b1000, 3'b000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [10:0] addr = '0;
    logic [3:0] cfg_trp = 4'd2, cfg_trc = 4'd3, cfg_burst = 4'd2;
    logic [3:0] bank_active, bank_ready;
    logic [43:0] open_row;
    logic [10:0] mode_word;
    logic viol_early, viol_state, viol_open;
    int n_chk = 0, n_fail = 0;

    sdram_bank_tracker u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [10:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b;
        addr = a;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 active", bank_active, 0);
        chk("R9 ready", bank_ready, 4'hF);
        chk("R9 mode", mode_word, 0);
        chk("R9 flags", {viol_early, viol_state, viol_open}, 0);

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][23:20], VEC[i][19:18], VEC[i][17:7]);
            chk($sformatf("R2/R10 vec%0d active", i), bank_active, VEC[i][6:3]);
            chk($sformatf("R10 vec%0d flags", i), {viol_early, viol_state, viol_open}, VEC[i][2:0]);
        end

        chk("R2 row bank3", open_row[33 +: 11], 11'h3C0);
        chk("R6 mode capture", mode_word, 11'h2A5);

        // R1: inhibited close-all leaves state alone
        for (int k = 0; k < 3; k++) begin
            issue({1'b1, 3'b010}, 2'd3, 11'h400);
            chk("R1 hold", bank_active, 4'b1000);
            chk("R1 flags", {viol_early, viol_state, viol_open}, 0);
        end

        // R6: rejected mode load keeps the word
        issue(C_MRS, 2'd0, 11'h111);
        chk("R6 open flag", viol_open, 1);
        chk("R6 word kept", mode_word, 11'h2A5);

        // R5: ready timing after a single close
        issue(C_PRE, 2'd3, 11'h000);
        chk("R4 close bank3", bank_active, 0);
        chk("R5 not ready", bank_ready[3], 0);
        issue(C_NOP, 2'd0, 11'h000);
        chk("R5 ready again", bank_ready[3], 1);

        // R8: self-closing write with a four-cycle burst
        cfg_burst = 4'd4;
        issue(C_ACT, 2'd1, 11'h0AA);
        chk("R2 row bank1", open_row[11 +: 11], 11'h0AA);
        issue(C_WR, 2'd1, 11'h407);
        for (int k = 0; k < 3; k++) begin
            issue(C_NOP, 2'd0, 11'h000);
            chk("R8 still open", bank_active[1], 1);
        end
        issue(C_NOP, 2'd0, 11'h000);
        chk("R8 closed at burst end", bank_active[1], 0);
        issue(C_NOP, 2'd0, 11'h000);

        // R7: refresh blocks every bank for cfg_trc cycles
        cfg_trc = 4'd5;
        issue(C_REF, 2'd0, 11'h000);
        chk("R7 blocked", bank_ready, 0);
        for (int k = 0; k < 3; k++) begin
            issue(C_NOP, 2'd0, 11'h000);
            chk("R7 still blocked", bank_ready, 0);
        end
        issue(C_NOP, 2'd0, 11'h000);
        chk("R7 released", bank_ready, 4'hF);

        // R9: reset in the middle of activity
        issue(C_ACT, 2'd2, 11'h321);
        chk("R2 open before reset", bank_active, 4'b0100);
        rst_n = 1'b0;
        issue(C_NOP, 2'd0, 11'h000);
        rst_n = 1'b1;
        chk("R9 active cleared", bank_active, 0);
        chk("R9 row cleared", open_row, 0);
        chk("R9 mode cleared", mode_word, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule